// File: doc/BRIEF.md
# Unrolled RC5 Block Encryption Core

This core encrypts one 64-bit block at a time with the RC5 cipher, using 32-bit words and a fixed 15 rounds. Before any block is started, the 32 round-key words must already sit in an internal key table. That table is filled one word at a time through a small write port. The key schedule itself is computed elsewhere.

A synthesis parameter sets how many rounds are evaluated per clock. Its value must divide 15, so it is one of 1, 3, 5 or 15. That many round stages are chained combinationally, and a small controller iterates the chain. A block therefore spends 15/UNROLL cycles in the round loop. A larger factor shortens the loop and lengthens the combinational path.

A request carries two plaintext words on a start strobe. The core raises `busy` while it works. It then pulses `done` for one cycle and holds the two ciphertext words steady until the next block completes.

Top module: `rc5u_enc_core`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are low and both ciphertext outputs read zero.
- R2: While `busy` is low, a cycle with `key_we` high stores `key_wdata` into key-table entry `key_waddr` (5-bit index, entries 0 to 31). Entry 0 is the first whitening word. Entry 1 is the second whitening word. Entries 2i and 2i+1 serve round i.
- R3: A `start` seen with `busy` low is accepted at that clock edge. `busy` is high in the 15/UNROLL cycles that follow and low in the next one.
- R4: `done` is high for exactly one cycle. That cycle follows the last busy cycle, with `busy` already low.
- R5: The ciphertext is standard RC5 with 32-bit words and 15 rounds. On acceptance, A = P0 + K[0] and B = P1 + K[1], both modulo 2^32. Round i (1 to 15) computes A = ((A xor B) rotl B[4:0]) + K[2i], and then B = ((B xor A) rotl A[4:0]) + K[2i+1], using the updated A.
- R6: Each rotation is to the left by the low 5 bits of the controlling word, and a rotation by 0 leaves the word unchanged. With an all-zero key table, an all-zero plaintext encrypts to all zeros.
- R7: `pt_a` is the first word of the block (A) and `pt_b` is the second (B). `ct_a` presents the final A and `ct_b` presents the final B.
- R8: `start` has no effect while `busy` is high. The running block finishes unchanged, and no further `done` follows.
- R9: A key-table write attempted while `busy` is high is ignored. The entry keeps its old value for all later blocks.
- R10: `ct_a` and `ct_b` change only in the cycle where `done` is high, and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key-table write strobe |
| key_waddr | input | 5 | Key-table entry index |
| key_wdata | input | 32 | Key word to store |
| start | input | 1 | Request to encrypt `pt_a`/`pt_b` |
| pt_a | input | 32 | First plaintext word (A) |
| pt_b | input | 32 | Second plaintext word (B) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |
| ct_a | output | 32 | First ciphertext word (A) |
| ct_b | output | 32 | Second ciphertext word (B) |

## Verification
The embedded assertions check several properties on every cycle:
- `done` never lasts longer than one cycle and never overlaps `busy`.
- `busy` only rises after an accepted `start`, and the run ends after the final iteration.
- The ciphertext registers hold outside the `done` cycle.
- The key table stays frozen while locked.

Only the bench's scenarios can show that the ciphertext values match the cipher under several key tables and plaintexts, including the all-zero rotation case. They also show that latency equals 15/UNROLL cycles, that words keep their order, and that a start or key write issued mid-block leaves later results unaffected.

// File: rtl/rc5u_pkg.sv
package rc5u_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_ROUNDS = 15;
    localparam int KEY_WORDS  = 2 * (NUM_ROUNDS + 1);
    localparam int KEY_AW     = $clog2(KEY_WORDS);
    localparam int ROT_W      = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
    } blk_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // left rotation by a 5-bit amount; amount 0 returns the word
    function automatic word_t rotl(word_t x, logic [ROT_W-1:0] n);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << n;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction

    // one full RC5 round, second half uses the updated A
    function automatic blk_t one_round(blk_t s, word_t ka, word_t kb);
        blk_t r;
        r.a = rotl(s.a ^ s.b, s.b[ROT_W-1:0]) + ka;
        r.b = rotl(s.b ^ r.a, r.a[ROT_W-1:0]) + kb;
        return r;
    endfunction
endpackage

// File: rtl/rc5u_keytab.sv
module rc5u_keytab
    import rc5u_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [KEY_AW-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [ITER_W-1:0] iter,
    output word_t             white_a,
    output word_t             white_b,
    output word_t             ka [LANES],
    output word_t             kb [LANES]
);
    logic [KEY_WORDS-1:0][WORD_W-1:0] mem;

    always_ff @(posedge clk) begin
        if (wr_en && !wr_lock) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign white_a = mem[0];
    assign white_b = mem[1];

    // round index for lane j in this iteration is iter*LANES + j + 1
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            ka[j] = mem[KEY_AW'(2 * (int'(iter) * LANES + j + 1))];
            kb[j] = mem[KEY_AW'(2 * (int'(iter) * LANES + j + 1) + 1)];
        end
    end

    // R9
    locked_table_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_lock) && $past(wr_en) && !$past(rst)) |-> $stable(mem));
endmodule

// File: rtl/rc5u_round_chain.sv
module rc5u_round_chain
    import rc5u_pkg::*;
#(
    parameter int LANES = 3
) (
    input  blk_t  din,
    input  word_t ka [LANES],
    input  word_t kb [LANES],
    output blk_t  dout
);
    blk_t stage [LANES+1];

    assign stage[0] = din;

    for (genvar j = 0; j < LANES; j++) begin : g_stage
        assign stage[j+1] = one_round(stage[j], ka[j], kb[j]);
    end

    assign dout = stage[LANES];
endmodule

// File: rtl/rc5u_ctrl.sv
module rc5u_ctrl
    import rc5u_pkg::*;
#(
    parameter int ITERS  = 5,
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic              last,
    output logic [ITER_W-1:0] iter,
    output logic              done
);
    run_state_e state;

    assign busy   = (state == ST_RUN);
    assign accept = start && (state == ST_IDLE);
    assign last   = busy && (iter == ITER_W'(ITERS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (accept) begin
                state <= ST_RUN;
                iter  <= '0;
            end else if (last) begin
                state <= ST_IDLE;
                iter  <= '0;
            end else if (busy) begin
                iter <= iter + 1'b1;
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3
    run_end_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> (!busy && done));

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/rc5u_enc_core.sv
module rc5u_enc_core
    import rc5u_pkg::*;
#(
    parameter int UNROLL = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        key_we,
    input  logic [4:0]  key_waddr,
    input  logic [31:0] key_wdata,
    input  logic        start,
    input  logic [31:0] pt_a,
    input  logic [31:0] pt_b,
    output logic        busy,
    output logic        done,
    output logic [31:0] ct_a,
    output logic [31:0] ct_b
);
    localparam int ITERS  = NUM_ROUNDS / UNROLL;
    localparam int ITER_W = (ITERS > 1) ? $clog2(ITERS) : 1;

    initial begin
        unroll_div_chk: assert ((NUM_ROUNDS % UNROLL) == 0 && UNROLL >= 1);
    end

    logic              accept;
    logic              last;
    logic [ITER_W-1:0] iter;
    word_t             white_a, white_b;
    word_t             ka [UNROLL];
    word_t             kb [UNROLL];
    blk_t              st_q;
    blk_t              chain_out;
    blk_t              ct_q;

    rc5u_ctrl #(.ITERS(ITERS), .ITER_W(ITER_W)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .accept(accept),
        .busy(busy), .last(last), .iter(iter), .done(done)
    );

    rc5u_keytab #(.LANES(UNROLL), .ITER_W(ITER_W)) keytab_i (
        .clk(clk), .rst(rst), .wr_en(key_we), .wr_lock(busy),
        .wr_addr(key_waddr), .wr_data(key_wdata), .iter(iter),
        .white_a(white_a), .white_b(white_b), .ka(ka), .kb(kb)
    );

    rc5u_round_chain #(.LANES(UNROLL)) chain_i (
        .din(st_q), .ka(ka), .kb(kb), .dout(chain_out)
    );

    always_ff @(posedge clk) begin
        if (accept) begin
            st_q.a <= pt_a + white_a;
            st_q.b <= pt_b + white_b;
        end else if (busy) begin
            st_q <= chain_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ct_q <= '0;
        end else if (last) begin
            ct_q <= chain_out;
        end
    end

    assign ct_a = ct_q.a;
    assign ct_b = ct_q.b;

    // R10
    ct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(ct_q));
endmodule

// File: tb/rc5u_enc_core_tb_top.sv
module rc5u_enc_core_tb_top;
    localparam int U     = 3;
    localparam int ITERS = 15 / U;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_we = 1'b0;
    logic [4:0]  key_waddr = '0;
    logic [31:0] key_wdata = '0;
    logic        start = 1'b0;
    logic [31:0] pt_a = '0;
    logic [31:0] pt_b = '0;
    logic        busy, done;
    logic [31:0] ct_a, ct_b;

    int checks = 0;
    int fails  = 0;
    logic [31:0] keys [32];

    always #2 clk = ~clk;

    rc5u_enc_core #(.UNROLL(U)) dut_i (
        .clk(clk), .rst(rst), .key_we(key_we), .key_waddr(key_waddr),
        .key_wdata(key_wdata), .start(start), .pt_a(pt_a), .pt_b(pt_b),
        .busy(busy), .done(done), .ct_a(ct_a), .ct_b(ct_b)
    );

    function automatic logic [31:0] m_rotl(logic [31:0] x, int n);
        int s = n % 32;
        if (s == 0) return x;
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic logic [63:0] model(logic [31:0] a0, logic [31:0] b0);
        logic [31:0] a, b;
        a = a0 + keys[0];
        b = b0 + keys[1];
        for (int i = 1; i <= 15; i++) begin
            a = m_rotl(a ^ b, int'(b[4:0])) + keys[2*i];
            b = m_rotl(b ^ a, int'(a[4:0])) + keys[2*i+1];
        end
        return {a, b};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_keys(int seed);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            keys[i]   = (seed == 0) ? 32'h0 :
                        (32'(i) * 32'h9E3779B9) ^ (32'(seed) * 32'h6F4A7C15);
            key_we    = 1'b1;
            key_waddr = 5'(i);
            key_wdata = keys[i];
        end
        @(negedge clk);
        key_we = 1'b0;
    endtask

    // issue one block and check timing plus result
    task automatic run_block(string req, logic [31:0] a, logic [31:0] b);
        logic [63:0] exp;
        exp = model(a, b);
        @(negedge clk);
        start = 1'b1; pt_a = a; pt_b = b;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= ITERS; k++) begin
            check({req, " R3 busy during run"}, {63'd0, busy}, 64'd1);
            check({req, " R4 no early done"}, {63'd0, done}, 64'd0);
            @(negedge clk);
        end
        check({req, " R3 busy low after run"}, {63'd0, busy}, 64'd0);
        check({req, " R4 done at latency"}, {63'd0, done}, 64'd1);
        check({req, " R5 R7 ciphertext"}, {ct_a, ct_b}, exp);
        @(negedge clk);
        check({req, " R4 done one cycle"}, {63'd0, done}, 64'd0);
        check({req, " R10 ct held"}, {ct_a, ct_b}, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset outputs", {62'd0, busy, done}, 64'd0);
        check("R1 reset ciphertext", {ct_a, ct_b}, 64'd0);
    endtask

    task automatic t_zero();
        load_keys(0);
        run_block("R6 zero key zero text", 32'h0, 32'h0);
    endtask

    task automatic t_vectors();
        load_keys(1);
        run_block("R2 vec1", 32'h98721827, 32'hBE7B1E6F);
        run_block("R5 vec2", 32'hFFFFFFFF, 32'h00000001);
        load_keys(7);
        run_block("R2 rekey vec3", 32'h0123ABCD, 32'h1F00001F);
        // swapped words must give a distinct, model-matching result
        run_block("R7 swapped", 32'h1F00001F, 32'h0123ABCD);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            check("R10 ct hold idle", {ct_a, ct_b},
                  model(32'h1F00001F, 32'h0123ABCD));
        end
    endtask

    task automatic t_start_busy();
        logic [63:0] exp;
        int dones = 0;
        exp = model(32'hCAFEF00D, 32'h13579BDF);
        @(negedge clk);
        start = 1'b1; pt_a = 32'hCAFEF00D; pt_b = 32'h13579BDF;
        @(negedge clk);
        pt_a = 32'h11111111; pt_b = 32'h22222222;
        for (int k = 1; k <= ITERS; k++) begin
            if (k == ITERS) start = 1'b0;
            if (done) dones++;
            @(negedge clk);
        end
        start = 1'b0;
        check("R8 done at latency", {63'd0, done}, 64'd1);
        check("R8 first block kept", {ct_a, ct_b}, exp);
        for (int k = 0; k < ITERS + 3; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R8 no extra done", 64'(dones), 64'd0);
        check("R8 busy idle", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_write_busy();
        @(negedge clk);
        start = 1'b1; pt_a = 32'h55AA55AA; pt_b = 32'h0F0F0F0F;
        @(negedge clk);
        start = 1'b0;
        key_we = 1'b1; key_waddr = 5'd5; key_wdata = ~keys[5];
        @(negedge clk);
        key_we = 1'b1; key_waddr = 5'd0; key_wdata = 32'hDEADBEEF;
        @(negedge clk);
        key_we = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        run_block("R9 write while busy ignored", 32'h55AA55AA, 32'h0F0F0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero();
        t_vectors();
        t_start_busy();
        t_write_busy();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule